// File: doc/BRIEF.md
# DMA Channel Address Sequencer

This block walks one DMA channel through a block transfer. A start pulse captures a control word, a source start address, a destination start address and a beat count. The channel then offers one beat at a time on a valid/ready handshake. Each accepted beat moves both addresses forward by their configured amounts and lowers the remaining count by one. When the final beat is accepted, the channel stops and applies the configured end-of-block action. That action can be a one-cycle interrupt pulse, a suspend that holds until `resume`, or both.

The beat handshake carries the back-pressure. `beat_valid` is high for as long as the channel has beats left to move. A beat completes on a rising clock edge where `beat_valid` and `beat_ready` are both high. While `beat_valid` is high and `beat_ready` is low, `src_addr`, `dst_addr`, `beat_size` and `beats_left` hold their values and `beat_valid` stays high. The downstream side may hold `beat_ready` low for any number of cycles. All other pins are plain control and status.

The control word layout is: bits [1:0] beat size, bits [3:2] end action, bit 4 source increment, bit 5 destination increment, bit 6 step select, bits [9:7] step exponent, bits [15:10] reserved.

Top module: `dma_addr_seq`

## Requirements
- R1: When control bit 4 (source increment) is 0, `src_addr` keeps its loaded value through every accepted beat of the block.
- R2: When control bit 5 (destination increment) is 0, `dst_addr` keeps its loaded value through every accepted beat of the block.
- R3: Control bits [1:0] select the beat size: 0 is 8-bit, 1 is 16-bit, 2 is 32-bit. One beat is 1 << code bytes, and `beat_size` presents the code for both the read and the write side of the transfer.
- R4: With control bit 6 (step select) at 0, an enabled destination advances by (1 << size) << step per beat, where step is bits [9:7], and an enabled source advances by 1 << size.
- R5: With step select at 1, an enabled source advances by (1 << size) << step per beat and an enabled destination advances by 1 << size.
- R6: `beats_left` loads the start count, with a count of 0 loaded as 1, and falls by one per accepted beat. The beat that takes it from 1 to 0 ends the block and drops `beat_valid` on the next cycle.
- R7: Control bits [3:2] pick the end action: 0 does nothing, 1 pulses `block_irq` for exactly one cycle, 2 sets `suspended`, 3 does both. `suspended` stays high until `resume` is seen.
- R8: Bits [15:10] of `ctrl_rd` read as zero whatever was written to them. The other bits read back as they were written at the last accepted start.
- R9: A start whose beat-size code is 3 sets `cfg_err` and does not start the channel. A later start with a valid beat size clears `cfg_err`.
- R10: While `beat_valid` is high and `beat_ready` is low, the addresses and `beats_left` hold and `beat_valid` stays high.
- R11: `start` is ignored while the channel is running or suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a block with the values on the load inputs |
| ctrl_in | input | 16 | Control word |
| src_start | input | AW | Source start address |
| dst_start | input | AW | Destination start address |
| count_in | input | CW | Beat count (0 is treated as 1) |
| resume | input | 1 | Leave the suspended state |
| beat_ready | input | 1 | Downstream accepts the offered beat |
| beat_valid | output | 1 | A beat is offered at the current addresses |
| src_addr | output | AW | Source address of the current beat |
| dst_addr | output | AW | Destination address of the current beat |
| beat_size | output | 2 | Beat-size code for both read and write |
| beats_left | output | CW | Beats still to be accepted |
| ctrl_rd | output | 16 | Captured control word, reserved bits zeroed |
| block_irq | output | 1 | One-cycle end-of-block interrupt |
| suspended | output | 1 | Channel suspended after a block |
| cfg_err | output | 1 | Last start carried the reserved beat size |

## Verification
The assertions run on every cycle and cover these properties: addresses and count stay put under back-pressure, disabled addresses stay fixed, the stepped address moves by the scaled stride, the interrupt lasts a single cycle, the reserved control bits stay zero, and a rejected start never raises `beat_valid`. Some behaviours depend on a scenario and can only be shown by the bench's directed runs against its cycle-level model. These are: zero-count promotion to one beat, each of the four end actions, the way suspend holds until `resume` and blocks new starts, and starts dropped in the middle of a block.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  localparam int CTRL_W = 16;
  localparam int STEP_W = 3;

  typedef enum logic [1:0] {
    BS_BYTE = 2'd0,
    BS_HALF = 2'd1,
    BS_WORD = 2'd2,
    BS_RSVD = 2'd3
  } beat_size_e;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_IRQ  = 2'd1,
    ACT_SUSP = 2'd2,
    ACT_BOTH = 2'd3
  } blk_act_e;

  typedef struct packed {
    logic [5:0]        rsvd;
    logic [STEP_W-1:0] step;
    logic              step_sel;
    logic              dst_inc;
    logic              src_inc;
    blk_act_e          act;
    beat_size_e        bsize;
  } ctrl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_SUSP = 2'd2
  } chan_st_e;
endpackage

// File: rtl/seq_addr_gen.sv
module seq_addr_gen #(
  parameter int AW     = 32,
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [AW-1:0]     start_addr,
  input  logic              adv,
  input  logic              inc_en,
  input  logic              use_step,
  input  logic [1:0]        bsize,
  input  logic [STEP_W-1:0] step,
  output logic [AW-1:0]     addr
);
  logic [AW-1:0] bytes;
  logic [AW-1:0] delta;

  always_comb begin
    bytes = AW'(1) << bsize;
    if (!inc_en)
      delta = '0;
    else if (use_step)
      delta = bytes << step;
    else
      delta = bytes;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      addr <= '0;
    else if (load)
      addr <= start_addr;
    else if (adv)
      addr <= addr + delta;
  end
endmodule

// File: rtl/seq_beat_cnt.sv
module seq_beat_cnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] count_in,
  input  logic          dec,
  output logic [CW-1:0] left,
  output logic          last
);
  assign last = (left == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)
      left <= '0;
    else if (load)
      left <= (count_in == '0) ? CW'(1) : count_in;
    else if (dec)
      left <= left - CW'(1);
  end
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import dma_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     bad_cfg,
  input  blk_act_e act,
  input  logic     ready,
  input  logic     last,
  input  logic     resume,
  output logic     take_cfg,
  output logic     load,
  output logic     hs,
  output logic     run,
  output logic     irq,
  output logic     susp,
  output logic     err
);
  chan_st_e st;

  assign take_cfg = (st == ST_IDLE) && start;
  assign load     = take_cfg && !bad_cfg;
  assign run      = (st == ST_RUN);
  assign hs       = run && ready;
  assign susp     = (st == ST_SUSP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      irq <= 1'b0;
      err <= 1'b0;
    end else begin
      irq <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (take_cfg) begin
            err <= bad_cfg;
            if (!bad_cfg)
              st <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (hs && last) begin
            irq <= act[0];
            st  <= act[1] ? ST_SUSP : ST_IDLE;
          end
        end
        ST_SUSP: begin
          if (resume)
            st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
  import dma_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CTRL_W-1:0] ctrl_in,
  input  logic [AW-1:0]     src_start,
  input  logic [AW-1:0]     dst_start,
  input  logic [CW-1:0]     count_in,
  input  logic              resume,
  input  logic              beat_ready,
  output logic              beat_valid,
  output logic [AW-1:0]     src_addr,
  output logic [AW-1:0]     dst_addr,
  output logic [1:0]        beat_size,
  output logic [CW-1:0]     beats_left,
  output logic [CTRL_W-1:0] ctrl_rd,
  output logic              block_irq,
  output logic              suspended,
  output logic              cfg_err
);
  localparam int NSIDE = 2;
  localparam logic [CTRL_W-1:0] RSVD_MASK = {6'b0, {(CTRL_W-6){1'b1}}};

  ctrl_t cfg_q;
  ctrl_t cfg_in;
  logic  take_cfg, load, hs, last;
  logic [AW-1:0] start_a [NSIDE];
  logic [AW-1:0] addr_a  [NSIDE];

  assign cfg_in = ctrl_t'(ctrl_in & RSVD_MASK);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cfg_q <= '0;
    else if (take_cfg)
      cfg_q <= cfg_in;
  end

  seq_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .bad_cfg  (cfg_in.bsize == BS_RSVD),
    .act      (cfg_q.act),
    .ready    (beat_ready),
    .last     (last),
    .resume   (resume),
    .take_cfg (take_cfg),
    .load     (load),
    .hs       (hs),
    .run      (beat_valid),
    .irq      (block_irq),
    .susp     (suspended),
    .err      (cfg_err)
  );

  seq_beat_cnt #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .count_in (count_in),
    .dec      (hs),
    .left     (beats_left),
    .last     (last)
  );

  assign start_a[0] = src_start;
  assign start_a[1] = dst_start;

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    logic inc_en;
    logic use_step;
    if (g == 0) begin : g_src
      assign inc_en   = cfg_q.src_inc;
      assign use_step = cfg_q.step_sel;
    end else begin : g_dst
      assign inc_en   = cfg_q.dst_inc;
      assign use_step = !cfg_q.step_sel;
    end
    seq_addr_gen #(.AW(AW), .STEP_W(STEP_W)) u_addr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .start_addr (start_a[g]),
      .adv        (hs),
      .inc_en     (inc_en),
      .use_step   (use_step),
      .bsize      (cfg_q.bsize),
      .step       (cfg_q.step),
      .addr       (addr_a[g])
    );
  end

  assign src_addr  = addr_a[0];
  assign dst_addr  = addr_a[1];
  assign beat_size = cfg_q.bsize;
  assign ctrl_rd   = cfg_q;
endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [15:0]   ctrl_in,
  input logic [AW-1:0] src_start,
  input logic [AW-1:0] dst_start,
  input logic [CW-1:0] count_in,
  input logic          resume,
  input logic          beat_ready,
  input logic          beat_valid,
  input logic [AW-1:0] src_addr,
  input logic [AW-1:0] dst_addr,
  input logic [1:0]    beat_size,
  input logic [CW-1:0] beats_left,
  input logic [15:0]   ctrl_rd,
  input logic          block_irq,
  input logic          suspended,
  input logic          cfg_err
);
  logic acc;
  assign acc = beat_valid && beat_ready;

  AST_SRC_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !ctrl_rd[4] |=> $stable(src_addr)); // R1
  AST_DST_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !ctrl_rd[5] |=> $stable(dst_addr)); // R2
  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> beat_size != 2'd3); // R3
  AST_DST_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    acc && ctrl_rd[5] && !ctrl_rd[6] |=>
      dst_addr == $past(dst_addr) + ((AW'(1) << $past(ctrl_rd[1:0])) << $past(ctrl_rd[9:7]))); // R4
  AST_SRC_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    acc && ctrl_rd[4] && ctrl_rd[6] |=>
      src_addr == $past(src_addr) + ((AW'(1) << $past(ctrl_rd[1:0])) << $past(ctrl_rd[9:7]))); // R5
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> beats_left == $past(beats_left) - CW'(1)); // R6
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    block_irq |=> !block_irq); // R7
  AST_SUSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> !beat_valid); // R7
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd[15:10] == 6'd0); // R8
  AST_BAD_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    start && !beat_valid && !suspended && ctrl_in[1:0] == 2'd3 |=> !beat_valid && cfg_err); // R9
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready |=>
      beat_valid && $stable(src_addr) && $stable(dst_addr) && $stable(beats_left)); // R10
  AST_RUN_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready && start |=> $stable(ctrl_rd)); // R11
endmodule

bind dma_addr_seq dma_seq_chk #(.AW(AW), .CW(CW)) u_chk (.*);

// File: tb/sim_dma_addr_seq.sv
`timescale 1ns/1ps
module sim_dma_addr_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] ctrl_in = '0;
  logic [31:0] src_start = '0, dst_start = '0;
  logic [15:0] count_in = '0;
  logic        resume = 1'b0, beat_ready = 1'b0;
  logic        beat_valid, block_irq, suspended, cfg_err;
  logic [31:0] src_addr, dst_addr;
  logic [1:0]  beat_size;
  logic [15:0] beats_left, ctrl_rd;

  always #2.5 clk = ~clk;

  dma_addr_seq u0 (.*);

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  // reference model state
  bit m_act, m_susp, m_err, m_irq;
  logic [31:0] m_src, m_dst;
  logic [15:0] m_left, m_ctrl;

  function automatic logic [15:0] mk(logic [1:0] bs, logic [1:0] act, logic si, logic di,
                                     logic ss, logic [2:0] st);
    return {6'b0, st, ss, di, si, act, bs};
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic model_step();
    logic [31:0] b, sd, dd;
    m_irq = 0;
    if (!rst_n) begin
      m_act = 0; m_susp = 0; m_err = 0; m_src = 0; m_dst = 0; m_left = 0; m_ctrl = 0;
    end else if (m_act) begin
      if (beat_ready) begin
        b  = 32'd1 << m_ctrl[1:0];
        sd = m_ctrl[4] ? (m_ctrl[6] ? b << m_ctrl[9:7] : b) : 0;
        dd = m_ctrl[5] ? (!m_ctrl[6] ? b << m_ctrl[9:7] : b) : 0;
        m_src = m_src + sd;
        m_dst = m_dst + dd;
        if (m_left == 1) begin
          m_act = 0; m_irq = m_ctrl[2]; m_susp = m_ctrl[3];
        end
        m_left = m_left - 1;
      end
    end else if (m_susp) begin
      if (resume) m_susp = 0;
    end else if (start) begin
      m_ctrl = ctrl_in & 16'h03FF;
      if (ctrl_in[1:0] == 2'd3) m_err = 1;
      else begin
        m_err = 0; m_act = 1; m_src = src_start; m_dst = dst_start;
        m_left = (count_in == 0) ? 16'd1 : count_in;
      end
    end
  endtask

  task automatic compare();
    chk(beat_valid == m_act,  "R11 beat_valid", beat_valid, m_act);
    chk(src_addr == m_src,    "R4 src_addr", src_addr, m_src);
    chk(dst_addr == m_dst,    "R5 dst_addr", dst_addr, m_dst);
    chk(beats_left == m_left, "R6 beats_left", beats_left, m_left);
    chk(block_irq == m_irq,   "R7 block_irq", block_irq, m_irq);
    chk(suspended == m_susp,  "R7 suspended", suspended, m_susp);
    chk(cfg_err == m_err,     "R9 cfg_err", cfg_err, m_err);
    chk(ctrl_rd == m_ctrl,    "R8 ctrl_rd", ctrl_rd, m_ctrl);
    chk(beat_size == m_ctrl[1:0], "R3 beat_size", beat_size, m_ctrl[1:0]);
  endtask

  // inputs are set after a falling edge; one call covers one rising edge
  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    cyc++;
    compare();
    start = 0; resume = 0;
  endtask

  task automatic launch(logic [15:0] c, logic [31:0] s, logic [31:0] d, logic [15:0] n);
    ctrl_in = c; src_start = s; dst_start = d; count_in = n; start = 1;
    tick();
  endtask

  task automatic drain(bit toggle);
    for (int i = 0; i < 200 && m_act; i++) begin
      beat_ready = toggle ? i[0] : 1'b1;
      tick();
    end
    beat_ready = 0;
  endtask

  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      fails++;
      $display("FAIL R6 watchdog expired actual=%0d expected=%0d", cyc, 20000);
      report();
    end
  end

  initial begin
    logic [31:0] s0, d0;
    @(negedge clk);
    tick(); tick();
    // reset state
    chk(!beat_valid && !block_irq && !suspended && !cfg_err, "R11 reset outputs",
        {beat_valid, block_irq, suspended, cfg_err}, 0);
    rst_n = 1;
    tick();

    // R4: bytes, both increment, destination stepped by 4, count 4, interrupt
    launch(mk(2'd0, 2'd1, 1, 1, 0, 3'd2), 32'h1000, 32'h2000, 16'd4);
    drain(0);
    chk(dst_addr == 32'h2010 && src_addr == 32'h1004, "R4 end addresses", dst_addr, 32'h2010);
    tick();

    // R5 / R2 / R10: halfwords, source stepped x8, destination fixed, back-pressure
    launch(mk(2'd1, 2'd0, 1, 0, 1, 3'd3), 32'h100, 32'h500, 16'd3);
    s0 = src_addr; d0 = dst_addr;
    beat_ready = 0; tick();
    chk(src_addr == s0 && beats_left == 16'd3, "R10 stall hold", src_addr, s0);
    drain(1);
    chk(src_addr == 32'h100 + 3 * 16, "R5 stepped source", src_addr, 32'h130);
    chk(dst_addr == d0, "R2 fixed destination", dst_addr, d0);
    chk(!block_irq && !suspended, "R7 no action", {block_irq, suspended}, 0);

    // R1 / R6: words, source fixed, count 0 -> one beat, suspend
    launch(mk(2'd2, 2'd2, 0, 1, 0, 3'd0), 32'hABC0, 32'h40, 16'd0);
    chk(beats_left == 16'd1, "R6 zero count loads one", beats_left, 1);
    drain(0);
    chk(src_addr == 32'hABC0, "R1 fixed source", src_addr, 32'hABC0);
    chk(suspended, "R7 suspend set", suspended, 1);
    // R11: start while suspended ignored
    launch(mk(2'd0, 2'd0, 1, 1, 0, 3'd0), 32'h9, 32'h9, 16'd2);
    chk(!beat_valid && ctrl_rd[1:0] == 2'd2, "R11 start while suspended", beat_valid, 0);
    tick(); tick();
    chk(suspended, "R7 suspend holds", suspended, 1);
    resume = 1; tick();
    chk(!suspended, "R7 resume clears", suspended, 0);

    // R9: reserved size rejected, then a valid start clears the flag
    launch(mk(2'd3, 2'd0, 1, 1, 0, 3'd0), 32'h1, 32'h2, 16'd5);
    chk(cfg_err && !beat_valid, "R9 reserved size", {cfg_err, beat_valid}, 2'b10);
    // R8: reserved control bits written as ones; action both
    launch(16'hFC00 | mk(2'd1, 2'd3, 1, 1, 1, 3'd1), 32'h800, 32'h900, 16'd2);
    chk(!cfg_err && ctrl_rd[15:10] == 0, "R8 reserved read zero", ctrl_rd, ctrl_rd & 16'h03FF);
    // R11: start during the block ignored
    beat_ready = 1;
    launch(mk(2'd0, 2'd0, 0, 0, 0, 3'd0), 32'h7, 32'h7, 16'd9);
    chk(ctrl_rd[1:0] == 2'd1 && beats_left == 16'd1, "R11 start while running", beats_left, 1);
    drain(0);
    chk(suspended, "R7 both: suspended", suspended, 1);
    resume = 1; tick();

    // R3: word size, both incrementing by one beat each (step select 1, step 0)
    launch(mk(2'd2, 2'd1, 1, 1, 1, 3'd0), 32'h0, 32'hFFFF_FFF8, 16'd3);
    drain(1);
    chk(src_addr == 32'd12 && dst_addr == 32'h4, "R3 word beats with wrap", dst_addr, 32'h4);
    tick(); tick();
    report();
  end
endmodule